// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This controller-side block takes a frame-based serial audio link into its halted low-power state and brings it back. On a host sleep request it waits for the next frame boundary. It sends one frame whose command slots carry a write of the powerdown value to the codec's power control register, then drives its frame-sync and serial-data outputs low and keeps them low. The codec stops the bit clock in response.

A quiet window follows the powerdown frame. It is timed on the free-running local clock because the bit clock is gone. No wake-up can start inside this window. A wake request made during the window is stored and carried out when the window closes. A warm wake drives frame sync high for a fixed pulse. A cold wake drives the codec reset line low for a fixed time. The block then waits for the bit clock to restart and resumes frame generation. It reports audio as allowed only after the codec's ready bit has been seen high in an input frame. Audio slot serialization is left to a neighbouring block, which reads `audio_ok`.

Top module: `ac_link_pwr_seq`

## Requirements
- R1: During and after system reset the codec reset output `ac_reset_n` is low. It stays low for exactly COLD_CYCLES local clocks after `rst_n` is released. Frame sync and serial data are low during that time.
- R2: Frames start only after a rising edge of `bit_clk` has been seen with the link reset released. Each frame lasts FRAME_BITS bit clocks, and `ac_sync` is high for the first 16 bit clocks of each frame.
- R3: The codec ready bit is the first serial input bit of each frame (bit index 0, sampled on the bit-clock rise). `audio_ok` is high only in normal frames and only while the most recent ready bit was 1.
- R4: A `sleep_req` pulse in normal operation makes the next frame the powerdown frame, and `audio_ok` is low from that frame on. The powerdown frame carries these bits, MSB first on `ac_sdata_out`. Indices 0..2 are 1: frame valid, command-address slot valid, command-data slot valid. Indices 3..15 are 0, so no audio slot is valid. Index 16 is 0, meaning write. Indices 17..23 hold the address 7'h26. Indices 24..35 are 0. Indices 36..51 hold PD_DATA (default 16'h1000, the PR4 bit 12). All later bits are 0. Normal frames carry 0 on every data bit.
- R5: From the end of the powerdown frame until a wake pulse starts, `ac_sync` and `ac_sdata_out` stay low and `link_halted` is high.
- R6: `quiet_busy` is high for exactly QUIET_CYCLES local clocks, starting right after the powerdown frame. By default that is four 48 kHz frame periods. Wake requests made during this window are held, and the wake pulse starts in the cycle after the window ends.
- R7: A warm wake drives `ac_sync` high for exactly WARM_CYCLES clocks, and `ac_reset_n` stays high.
- R8: A cold wake drives `ac_reset_n` low for exactly COLD_CYCLES clocks with `ac_sync` low. When both kinds are requested, cold wins.
- R9: After a wake pulse, no frame sync appears until `bit_clk` rises again. `audio_ok` stays low until a frame has delivered a ready bit of 1.
- R10: Wake requests are ignored during normal operation. A sleep request is ignored unless the link is in normal operation, so the first frame after a wake is a normal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low system reset |
| sleep_req | input | 1 | Host request to halt the link |
| wake_warm_req | input | 1 | Host request for a warm wake |
| wake_cold_req | input | 1 | Host request for a cold wake |
| bit_clk | input | 1 | Bit clock from the codec, asynchronous |
| sdata_in | input | 1 | Serial input data from the codec |
| ac_sync | output | 1 | Frame sync to the codec |
| ac_sdata_out | output | 1 | Serial output data to the codec |
| ac_reset_n | output | 1 | Active-low codec reset |
| audio_ok | output | 1 | Audio traffic permitted |
| link_halted | output | 1 | Link is in the quiet window or halted |
| quiet_busy | output | 1 | Minimum-idle window running |

## Verification
A wrong sequencer state shows up on the link pins within one local clock. A halted or quiet state that lets sync through, or a pulse state that ends early, changes the counted widths of `quiet_busy`, `ac_sync` or `ac_reset_n` by at least one cycle. A frame counter or slot-encoding fault shows within the one captured powerdown frame as a wrong bit at a known index. A stale ready flag shows on `audio_ok` within the first frame after a wake.

// File: rtl/ac_pwr_pkg.sv
package ac_pwr_pkg;

  typedef enum logic [2:0] {
    ST_COLD    = 3'd0,
    ST_WAITCLK = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_PDFRAME = 3'd3,
    ST_QUIET   = 3'd4,
    ST_HALTED  = 3'd5,
    ST_WARM    = 3'd6
  } pwr_state_e;

  localparam int unsigned SYNC_BITS = 16;
  localparam logic [6:0]  PWR_REG_ADDR = 7'h26;

  // number of local clocks covering n frames at the given frame rate, rounded up
  function automatic int unsigned frames_to_clocks(int unsigned clk_hz, int unsigned rate_hz,
                                                   int unsigned n);
    return (n * clk_hz + rate_hz - 1) / rate_hz;
  endfunction

  // bit of the powerdown frame at serial position idx (0 = first after sync rise)
  function automatic logic pd_frame_bit(int unsigned idx, logic [15:0] data);
    if (idx < 3)  return 1'b1;                       // frame, slot1, slot2 valid
    if (idx < 17) return 1'b0;                       // rest of tag, write flag
    if (idx < 24) return PWR_REG_ADDR[3'(23 - idx)]; // register address
    if (idx < 36) return 1'b0;
    if (idx < 52) return data[4'(51 - idx)];         // register data
    return 1'b0;
  endfunction

endpackage

// File: rtl/ac_link_sync.sv
module ac_link_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic sdin_in,
  output logic bclk_rise,
  output logic sdin_s
);
  logic [2:0] bq;
  logic [1:0] dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq <= '0;
      dq <= '0;
    end else begin
      bq <= {bq[1:0], bclk_in};
      dq <= {dq[0], sdin_in};
    end
  end

  assign bclk_rise = bq[1] & ~bq[2];
  assign sdin_s    = dq[1];
endmodule

// File: rtl/ac_interval_timer.sv
module ac_interval_timer #(
  parameter int unsigned TW      = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= TW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ac_frame_gen.sv
module ac_frame_gen
  import ac_pwr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter logic [15:0] PD_DATA    = 16'h1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  logic pd_sel,
  output logic at_start,
  output logic at_last,
  output logic sync_o,
  output logic sdo_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      sync_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else if (!run) begin
      idx    <= '0;
      sync_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else if (step) begin
      sync_o <= (int'(idx) < SYNC_BITS);
      sdo_o  <= pd_sel & pd_frame_bit(int'(idx), PD_DATA);
      idx    <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assign at_start = (idx == '0);
  assign at_last  = (idx == LAST);
endmodule

// File: rtl/ac_link_pwr_seq.sv
module ac_link_pwr_seq
  import ac_pwr_pkg::*;
#(
  parameter int unsigned FRAME_BITS    = 256,
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned FRAME_RATE_HZ = 48_000,
  parameter int unsigned QUIET_CYCLES  = frames_to_clocks(CLK_HZ, FRAME_RATE_HZ, 4),
  parameter int unsigned WARM_CYCLES   = 100,
  parameter int unsigned COLD_CYCLES   = 200,
  parameter logic [15:0] PD_DATA       = 16'h1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_warm_req,
  input  logic wake_cold_req,
  input  logic bit_clk,
  input  logic sdata_in,
  output logic ac_sync,
  output logic ac_sdata_out,
  output logic ac_reset_n,
  output logic audio_ok,
  output logic link_halted,
  output logic quiet_busy
);
  localparam int unsigned MAX_A = (QUIET_CYCLES > WARM_CYCLES) ? QUIET_CYCLES : WARM_CYCLES;
  localparam int unsigned MAX_C = (MAX_A > COLD_CYCLES) ? MAX_A : COLD_CYCLES;
  localparam int unsigned TW    = $clog2(MAX_C + 1);

  pwr_state_e st, nxt;
  logic bclk_rise, sdin_s;
  logic t_load, t_exp;
  logic [TW-1:0] t_val;
  logic at_start, at_last, gen_sync, gen_sdo;
  logic sleep_pend, warm_pend, cold_pend, ready_q;

  // named internal events, also used by the checker
  logic gen_run, in_pd, in_warm, frame_edge, cold_wanted, warm_wanted;
  assign gen_run     = (st == ST_ACTIVE) || (st == ST_PDFRAME);
  assign in_pd       = (st == ST_PDFRAME);
  assign in_warm     = (st == ST_WARM);
  assign frame_edge  = bclk_rise & at_start;
  assign cold_wanted = cold_pend | wake_cold_req;
  assign warm_wanted = warm_pend | wake_warm_req;

  ac_link_sync i_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(bit_clk), .sdin_in(sdata_in),
    .bclk_rise(bclk_rise), .sdin_s(sdin_s)
  );

  ac_interval_timer #(.TW(TW), .RST_VAL(COLD_CYCLES - 1)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  ac_frame_gen #(.FRAME_BITS(FRAME_BITS), .PD_DATA(PD_DATA)) i_gen (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .step(bclk_rise),
    .pd_sel(in_pd | ((st == ST_ACTIVE) & sleep_pend & at_start)),
    .at_start(at_start), .at_last(at_last), .sync_o(gen_sync), .sdo_o(gen_sdo)
  );

  always_comb begin
    nxt    = st;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_COLD:    if (t_exp) nxt = ST_WAITCLK;
      ST_WAITCLK: if (bclk_rise) nxt = ST_ACTIVE;
      ST_ACTIVE:  if (frame_edge && sleep_pend) nxt = ST_PDFRAME;
      ST_PDFRAME: if (bclk_rise && at_last) begin
        nxt    = ST_QUIET;
        t_load = 1'b1;
        t_val  = TW'(QUIET_CYCLES - 1);
      end
      ST_QUIET, ST_HALTED: if (st == ST_HALTED || t_exp) begin
        if (cold_wanted) begin
          nxt = ST_COLD;  t_load = 1'b1; t_val = TW'(COLD_CYCLES - 1);
        end else if (warm_wanted) begin
          nxt = ST_WARM;  t_load = 1'b1; t_val = TW'(WARM_CYCLES - 1);
        end else begin
          nxt = ST_HALTED;
        end
      end
      ST_WARM:    if (t_exp) nxt = ST_WAITCLK;
      default:    nxt = ST_COLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_COLD;
      sleep_pend <= 1'b0;
      warm_pend  <= 1'b0;
      cold_pend  <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      st <= nxt;
      if (st != ST_ACTIVE || nxt == ST_PDFRAME) sleep_pend <= 1'b0;
      else if (sleep_req)                       sleep_pend <= 1'b1;
      if (st != ST_QUIET || nxt != ST_QUIET) begin
        warm_pend <= 1'b0;
        cold_pend <= 1'b0;
      end else begin
        warm_pend <= warm_pend | wake_warm_req;
        cold_pend <= cold_pend | wake_cold_req;
      end
      if (!gen_run)        ready_q <= 1'b0;
      else if (frame_edge) ready_q <= sdin_s;
    end
  end

  assign ac_sync      = gen_sync | in_warm;
  assign ac_sdata_out = gen_sdo;
  assign ac_reset_n   = (st != ST_COLD);
  assign audio_ok     = (st == ST_ACTIVE) & ready_q;
  assign link_halted  = (st == ST_QUIET) || (st == ST_HALTED);
  assign quiet_busy   = (st == ST_QUIET);
endmodule

// File: rtl/ac_link_pwr_seq_chk.sv
module ac_link_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ac_sync,
  input logic ac_sdata_out,
  input logic ac_reset_n,
  input logic audio_ok,
  input logic link_halted,
  input logic quiet_busy,
  input logic in_warm,
  input logic in_pd,
  input logic gen_run,
  input logic ready_q
);
  p_quiet_after_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiet_busy) |-> $past(in_pd));

  p_halted_pins_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_halted |-> (!ac_sync && !ac_sdata_out));

  p_cold_pins_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_reset_n |-> (!ac_sync && !ac_sdata_out));

  p_warm_keeps_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_warm |-> ac_reset_n);

  p_audio_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    audio_ok |-> (ready_q && gen_run && !in_pd));

  p_sync_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ac_sync) |-> (in_warm || gen_run));
endmodule

bind ac_link_pwr_seq ac_link_pwr_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ac_sync(ac_sync), .ac_sdata_out(ac_sdata_out),
  .ac_reset_n(ac_reset_n), .audio_ok(audio_ok), .link_halted(link_halted),
  .quiet_busy(quiet_busy), .in_warm(in_warm), .in_pd(in_pd),
  .gen_run(gen_run), .ready_q(ready_q)
);

// File: tb/test_ac_link_pwr_seq.sv
module test_ac_link_pwr_seq;
  localparam int F = 64;
  localparam int Q = 600;
  localparam int W = 100;
  localparam int C = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_warm_req = 1'b0, wake_cold_req = 1'b0;
  logic bit_clk = 1'b0, sdata_in = 1'b0;
  logic ac_sync, ac_sdata_out, ac_reset_n, audio_ok, link_halted, quiet_busy;

  int total = 0, bad = 0;
  int qcnt = 0, scnt = 0, ccnt = 0;

  always #5 clk = ~clk;

  ac_link_pwr_seq #(.FRAME_BITS(F), .QUIET_CYCLES(Q), .WARM_CYCLES(W),
                    .COLD_CYCLES(C)) i_ac_link_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_warm_req(wake_warm_req),
    .wake_cold_req(wake_cold_req), .bit_clk(bit_clk), .sdata_in(sdata_in),
    .ac_sync(ac_sync), .ac_sdata_out(ac_sdata_out), .ac_reset_n(ac_reset_n),
    .audio_ok(audio_ok), .link_halted(link_halted), .quiet_busy(quiet_busy)
  );

  always @(negedge clk) begin
    if (quiet_busy)  qcnt++;
    if (ac_sync)     scnt++;
    if (!ac_reset_n) ccnt++;
  end

  function automatic logic [63:0] exp_sync_vec();
    return {{16{1'b1}}, 48'd0};
  endfunction

  function automatic logic [63:0] exp_pd_vec();
    return {3'b111, 13'd0, 1'b0, 7'h26, 12'd0, 16'h1000, 12'd0};
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic bcyc(input bit pulse_sleep, output logic s, output logic d);
    bit_clk = 1'b1;
    repeat (5) @(negedge clk);
    s = ac_sync;
    d = ac_sdata_out;
    @(negedge clk);
    bit_clk = 1'b0;
    if (pulse_sleep) begin
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      repeat (5) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic frame(input int sleep_at, output logic [63:0] sv, output logic [63:0] dv);
    for (int i = 0; i < F; i++) begin
      logic s, d;
      bcyc(i == sleep_at, s, d);
      sv[63-i] = s;
      dv[63-i] = d;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1..all act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] sv, dv;
    logic s0, d0;
    int n, qb, sb, cb;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 reset pins", {60'd0, ac_reset_n, ac_sync, ac_sdata_out, audio_ok}, 64'd0);
    rst_n = 1'b1;
    n = 0;
    while (!ac_reset_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R1 cold length after reset", 64'(n), 64'(C));

    // first bring-up, codec not ready
    sdata_in = 1'b0;
    bcyc(1'b0, s0, d0);
    frame(-1, sv, dv);
    chk("R2 sync pattern", sv, exp_sync_vec());
    chk("R4 normal frame data", dv, 64'd0);
    chk("R3 not ready blocks audio", 64'(audio_ok), 64'd0);
    sdata_in = 1'b1;
    frame(-1, sv, dv);
    chk("R3 ready enables audio", 64'(audio_ok), 64'd1);

    // R10: wake requests in normal operation are ignored
    cb = ccnt;
    sb = scnt;
    wake_cold_req = 1'b1;
    wake_warm_req = 1'b1;
    @(negedge clk);
    wake_cold_req = 1'b0;
    wake_warm_req = 1'b0;
    frame(-1, sv, dv);
    chk("R10 wake ignored reset", 64'(ccnt - cb), 64'd0);
    chk("R10 wake ignored sync", sv, exp_sync_vec());
    chk("R10 audio kept", 64'(audio_ok), 64'd1);

    for (int it = 0; it < 7; it++) begin
      int mode, off, hold, badc;
      bit during, cold;
      mode   = (it < 5) ? it : int'($urandom_range(0, 4));
      off    = int'($urandom_range(20, Q - 40));
      during = (mode == 1) || (mode == 2) || (mode == 3);
      cold   = (mode == 1) || (mode == 2) || (mode == 4);
      qb = qcnt;
      frame(20, sv, dv);
      chk("R4 frame before powerdown", dv, 64'd0);
      frame(-1, sv, dv);
      chk("R4 powerdown frame data", dv, exp_pd_vec());
      chk("R4 powerdown frame sync", sv, exp_sync_vec());
      chk("R4 audio off in powerdown", 64'(audio_ok), 64'd0);
      sb = scnt;
      cb = ccnt;
      if (during) begin
        while (qcnt - qb < off) @(negedge clk);
        wake_cold_req = cold;
        wake_warm_req = (mode != 1);
        @(negedge clk);
        wake_cold_req = 1'b0;
        wake_warm_req = 1'b0;
      end
      while (quiet_busy) @(negedge clk);
      if (!during) begin
        hold = int'($urandom_range(10, 60));
        badc = 0;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int k = 0; k < hold; k++) begin
          if (!link_halted || ac_sync || ac_sdata_out) badc++;
          @(negedge clk);
        end
        chk("R5 halted pins low", 64'(badc), 64'd0);
        wake_cold_req = cold;
        wake_warm_req = !cold;
        @(negedge clk);
        wake_cold_req = 1'b0;
        wake_warm_req = 1'b0;
      end
      n = 0;
      while ((!ac_reset_n || ac_sync) && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk("R6 quiet window length", 64'(qcnt - qb), 64'(Q));
      chk("R8 cold pulse length", 64'(ccnt - cb), cold ? 64'(C) : 64'd0);
      chk("R7 warm pulse length", 64'(scnt - sb), cold ? 64'd0 : 64'(W));
      sb = scnt;
      repeat (20) @(negedge clk);
      chk("R9 no sync without bit clock", 64'(scnt - sb), 64'd0);
      chk("R9 audio held off", 64'(audio_ok), 64'd0);
      sdata_in = 1'b0;
      bcyc(1'b0, s0, d0);
      frame(-1, sv, dv);
      chk("R9 frames resume", sv, exp_sync_vec());
      chk("R10 no stale sleep", dv, 64'd0);
      chk("R9 audio waits for ready", 64'(audio_ok), 64'd0);
      sdata_in = 1'b1;
      frame(-1, sv, dv);
      chk("R3 ready after wake", 64'(audio_ok), 64'd1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule